// File: doc/BRIEF.md
# Per-Module Software Reset Controller

This block holds a bank of one-bit software reset registers, one per peripheral or submodule. It drives one reset output into the clock domain of each module. A module is held in reset in three cases: its software bit is cleared, the chip power-on reset is low, or a watchdog reset is active. The software bit is active-low. It comes up at 1, which means the module runs. Writing 0 holds the module in reset until software writes 1 back.

Each reset output asserts at once, without waiting for a clock. It releases through a two-stage synchronizer clocked by that module's own clock, so every module leaves reset cleanly in its own domain.

Some registers are marked critical by a parameter mask because they cover the path through which the bank itself is reached. Clearing a critical bit returns the whole bank to its reset value on the next bus clock. The reset it causes is therefore a short pulse. The bank itself is reset only by power-on or watchdog reset.

Top module: `swrst_bank`

## Requirements
- R1: While `por_n` is low, every `dom_rst_n` bit is low. After one `clk` edge with `por_n` low, every register reads 1. Every `dom_rst_n` is high by the third `clk` edge after `por_n` rises.
- R2: Register i sits at byte offset 4*i (word index `bus_addr[ADDR_W-1:2]`). A read returns the stored bit in `bus_rdata[0]`. Bits `bus_addr[1:0]` are ignored.
- R3: A write with `bus_wdata[0]`=0 to mapped register i clears that register. `dom_rst_n[i]` goes low right after that `clk` edge.
- R4: A cleared register keeps `dom_rst_n[i]` low until a write with `bus_wdata[0]`=1. After such a write, `dom_rst_n[i]` rises on the second rising edge of `dom_clk[i]`.
- R5: While `wdt_rst` is high, every `dom_rst_n` bit is low without waiting for a clock edge. After one `clk` edge with `wdt_rst` high, every register reads 1.
- R6: Writes use only `bus_wdata[0]`. Reads always return 0 in `bus_rdata[31:1]`.
- R7: A word index at or above NUM_MOD reads 0, and a write to it changes no register.
- R8: Clearing a register whose CRIT_MASK bit is 1 makes it read 0 for one `clk` cycle. On the next `clk` edge every register returns to 1. `dom_rst_n` of that module rises 3 edges after the write edge.
- R9: Clearing or setting one register leaves every other module's `dom_rst_n` unchanged.
- R10: `bus_rdata` is 0 unless `bus_sel`=1 and `bus_wr`=0. An access with `bus_sel`=0 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock for the register bank |
| por_n | input | 1 | Power-on reset, active low |
| wdt_rst | input | 1 | Watchdog reset, active high |
| bus_sel | input | 1 | Access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the bank |
| bus_wdata | input | 32 | Write data (bit 0 used) |
| bus_rdata | output | 32 | Read data, combinational |
| dom_clk | input | NUM_MOD | Clock of each target module |
| dom_rst_n | output | NUM_MOD | Synchronized reset per module, active low |

## Verification
The bench builds the block with its defaults: six modules, a 6-bit address, and modules 0 and 2 marked critical. This leaves ten unmapped word slots in the address space, so reads and writes above the mapped range can be exercised. It also places a critical and a non-critical register side by side, so the bank-wide restore can be checked against an independently cleared neighbour. All domain clocks are tied to the bench clock, which makes the two-edge release and the three-edge critical pulse exact cycle counts that the bench can check.

// File: rtl/swrst_pkg.sv
// Shared definitions for the software reset bank.
// Assumes a 32-bit data path and word-aligned registers.
package swrst_pkg;

    localparam int DATA_W     = 32;
    localparam int BYTE_SHIFT = 2;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_t;

    // Classify a bus cycle from its select and direction
    function automatic acc_kind_t classify(input logic sel, input logic wr);
        if (!sel)
            return ACC_IDLE;
        return wr ? ACC_WRITE : ACC_READ;
    endfunction

endpackage

// File: rtl/swrst_decode.sv
// Address decoder: turns a byte address into one-hot read and write
// strobes, one per implemented register. Word indices at or above
// NUM_MOD hit nothing. The two byte-lane bits are ignored.
module swrst_decode
    import swrst_pkg::*;
#(
    parameter int NUM_MOD = 6,
    parameter int ADDR_W  = 6
) (
    input  logic               sel,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_MOD-1:0] rd_hit,
    output logic [NUM_MOD-1:0] wr_hit
);
    localparam int IDX_W = ADDR_W - BYTE_SHIFT;

    logic [IDX_W-1:0] idx;
    logic [1:0]       unused_lane;
    acc_kind_t        kind;

    assign idx         = addr[ADDR_W-1:BYTE_SHIFT];
    assign unused_lane = addr[BYTE_SHIFT-1:0];
    assign kind        = classify(sel, wr);

    for (genvar i = 0; i < NUM_MOD; i++) begin : g_hit
        // Strobe register i when the word index matches
        always_comb begin
            rd_hit[i] = (kind == ACC_READ)  && (idx == IDX_W'(i));
            wr_hit[i] = (kind == ACC_WRITE) && (idx == IDX_W'(i));
        end
    end
endmodule

// File: rtl/swrst_regfile.sv
// One-bit active-low software reset registers. Bank reset is
// synchronous and comes from power-on, watchdog, or a cleared
// critical register (its reset also covers the bank's access path).
// Assumes por_n and wdt_rst are stable around clk edges.
module swrst_regfile #(
    parameter int                 NUM_MOD   = 6,
    parameter logic [NUM_MOD-1:0] CRIT_MASK = 6'b000101
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               wdt_rst,
    input  logic [NUM_MOD-1:0] wr_hit,
    input  logic               wbit,
    output logic [NUM_MOD-1:0] sw_n
);
    logic crit_cleared;
    logic bank_rst_n;

    // A cleared critical bit resets the whole bank
    always_comb begin
        crit_cleared = |(~sw_n & CRIT_MASK);
        bank_rst_n   = por_n && !wdt_rst && !crit_cleared;
    end

    for (genvar i = 0; i < NUM_MOD; i++) begin : g_bit
        // Hold, load from the bus, or return to 1 on bank reset
        always_ff @(posedge clk) begin
            if (!bank_rst_n)
                sw_n[i] <= 1'b1;
            else if (wr_hit[i])
                sw_n[i] <= wbit;
        end
    end
endmodule

// File: rtl/swrst_sync.sv
// Reset synchronizer: asserts at once when src_rst_n falls and
// releases after STAGES rising edges of dom_clk. Unlike the rest of
// the block, this one reset is asynchronous on purpose.
module swrst_sync #(
    parameter int STAGES = 2
) (
    input  logic dom_clk,
    input  logic src_rst_n,
    output logic rst_n
);
    logic [STAGES-1:0] stg;

    // Shift ones in after the source releases
    always_ff @(posedge dom_clk or negedge src_rst_n) begin
        if (!src_rst_n)
            stg <= '0;
        else
            stg <= {stg[STAGES-2:0], 1'b1};
    end

    assign rst_n = stg[STAGES-1];
endmodule

// File: rtl/swrst_bank.sv
// Top of the per-module software reset controller. Decodes the bus,
// holds the register bank, and combines each register with the
// power-on and watchdog resets before synchronizing it into its
// module's clock domain.
module swrst_bank
    import swrst_pkg::*;
#(
    parameter int                 NUM_MOD     = 6,
    parameter int                 ADDR_W      = 6,
    parameter int                 SYNC_STAGES = 2,
    parameter logic [NUM_MOD-1:0] CRIT_MASK   = 6'b000101
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               wdt_rst,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_MOD-1:0] dom_clk,
    output logic [NUM_MOD-1:0] dom_rst_n
);
    logic [NUM_MOD-1:0] rd_hit;
    logic [NUM_MOD-1:0] wr_hit;
    logic [NUM_MOD-1:0] sw_n;
    logic [NUM_MOD-1:0] src_n;
    logic [30:0]        unused_wdata;

    assign unused_wdata = bus_wdata[31:1];

    swrst_decode #(.NUM_MOD(NUM_MOD), .ADDR_W(ADDR_W)) u_dec (
        .sel    (bus_sel),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .rd_hit (rd_hit),
        .wr_hit (wr_hit)
    );

    swrst_regfile #(.NUM_MOD(NUM_MOD), .CRIT_MASK(CRIT_MASK)) u_regs (
        .clk     (clk),
        .por_n   (por_n),
        .wdt_rst (wdt_rst),
        .wr_hit  (wr_hit),
        .wbit    (bus_wdata[0]),
        .sw_n    (sw_n)
    );

    // Read mux: only bit 0 is implemented
    always_comb begin
        bus_rdata    = '0;
        bus_rdata[0] = |(rd_hit & sw_n);
    end

    for (genvar i = 0; i < NUM_MOD; i++) begin : g_dom
        // Any of the three sources holds the module in reset
        always_comb src_n[i] = sw_n[i] && por_n && !wdt_rst;

        swrst_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .dom_clk   (dom_clk[i]),
            .src_rst_n (src_n[i]),
            .rst_n     (dom_rst_n[i])
        );
    end
endmodule

// File: rtl/swrst_bank_chk.sv
// Assertion checker bound to swrst_bank. It watches only the ports.
module swrst_bank_chk #(
    parameter int NUM_MOD = 6,
    parameter int ADDR_W  = 6
) (
    input logic               clk,
    input logic               por_n,
    input logic               wdt_rst,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_wdata,
    input logic [31:0]        bus_rdata,
    input logic [NUM_MOD-1:0] dom_clk,
    input logic [NUM_MOD-1:0] dom_rst_n
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             seen_edge;

    assign idx = bus_addr[ADDR_W-1:2];

    // Skip the very first edge for the immediate checks
    always_ff @(posedge clk) seen_edge <= 1'b1;

    // Reset sources must hold every domain output low
    always @(posedge clk) begin
        if (seen_edge === 1'b1 && !por_n)
            assert_por_holds_R1: assert (dom_rst_n == '0);
        if (seen_edge === 1'b1 && wdt_rst)
            assert_wdt_holds_R5: assert (dom_rst_n == '0);
    end

    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!por_n)
        bus_rdata[31:1] == '0);

    assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!por_n)
        (bus_sel && !bus_wr && idx >= IDX_W'(NUM_MOD)) |-> bus_rdata == '0);

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!por_n)
        !bus_sel |-> bus_rdata == '0);

    for (genvar i = 0; i < NUM_MOD; i++) begin : g_mod
        assert_clear_holds_R3: assert property (@(posedge clk) disable iff (!por_n)
            (bus_sel && bus_wr && idx == IDX_W'(i) && !bus_wdata[0] && !wdt_rst)
            |=> !dom_rst_n[i]);

        assert_release_clean_R4: assert property (@(posedge dom_clk[i]) disable iff (!por_n)
            $rose(dom_rst_n[i]) |-> (!wdt_rst && !$past(wdt_rst)));
    end
endmodule

bind swrst_bank swrst_bank_chk #(.NUM_MOD(NUM_MOD), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .wdt_rst   (wdt_rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .dom_clk   (dom_clk),
    .dom_rst_n (dom_rst_n)
);

// File: tb/swrst_bank_test.sv
// Self-checking bench for swrst_bank: a vector table for register
// access, then directed tests for reset, timing and critical bits.
module swrst_bank_test;
    localparam int NM = 6;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          wdt_rst = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NM-1:0] dom_clk;
    logic [NM-1:0] dom_rst_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;
    assign dom_clk = {NM{clk}};

    swrst_bank uut (
        .clk (clk), .por_n (por_n), .wdt_rst (wdt_rst),
        .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .dom_clk (dom_clk), .dom_rst_n (dom_rst_n)
    );

    // Vector: {wr, addr, wdata, expected read}
    localparam logic [70:0] VEC [0:13] = '{
        {1'b0, 6'h00, 32'h0,         32'h1},
        {1'b0, 6'h14, 32'h0,         32'h1},
        {1'b1, 6'h04, 32'hFFFF_FFFE, 32'h0},
        {1'b0, 6'h04, 32'h0,         32'h0},
        {1'b0, 6'h08, 32'h0,         32'h1},
        {1'b1, 6'h18, 32'h0,         32'h0},
        {1'b0, 6'h18, 32'h0,         32'h0},
        {1'b0, 6'h3C, 32'h0,         32'h0},
        {1'b1, 6'h0D, 32'h0,         32'h0},
        {1'b0, 6'h0C, 32'h0,         32'h0},
        {1'b1, 6'h04, 32'h1,         32'h0},
        {1'b0, 6'h04, 32'h0,         32'h1},
        {1'b1, 6'h0C, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 6'h0F, 32'h0,         32'h1}
    };
    localparam string TAGS [0:13] = '{
        "R2", "R2", "R3", "R3 R6", "R9", "R7", "R7", "R7",
        "R2", "R2 lane", "R4", "R4", "R6", "R2 lane"
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // One bus write spanning one clk edge; returns at the next negedge
    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // Read within the low phase, consuming no edge
    task automatic quick_read(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2;
        check(tag, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 por holds domains", 32'(dom_rst_n), 32'h0);
        quick_read("R1 bank reset value", 6'h0C, 32'h1);
        por_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 release after por", 32'(dom_rst_n), 32'h3F);

        // Vector table walk (R2 R3 R4 R6 R7 R9)
        for (int v = 0; v < 14; v++) begin
            @(negedge clk);
            bus_sel = 1'b1; bus_wr = VEC[v][70]; bus_addr = VEC[v][69:64];
            bus_wdata = VEC[v][63:32];
            #2;
            if (!VEC[v][70])
                check(TAGS[v], bus_rdata, VEC[v][31:0]);
        end
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 R7 all domains free", 32'(dom_rst_n), 32'h3F);

        // R10: idle read and unselected write
        bus_addr = 6'h10; bus_wr = 1'b0; #2;
        check("R10 idle read zero", bus_rdata, 32'h0);
        @(negedge clk);
        bus_wr = 1'b1; bus_wdata = 32'h0;
        @(negedge clk);
        bus_wr = 1'b0;
        quick_read("R10 unselected write ignored", 6'h10, 32'h1);

        // R3 / R4 / R9: clear module 4, then release with exact timing
        do_write(6'h10, 32'h0);
        check("R3 domain low after write", 32'(dom_rst_n), 32'h2F);
        repeat (4) @(negedge clk);
        check("R4 stays low, R9 others free", 32'(dom_rst_n), 32'h2F);
        do_write(6'h10, 32'h1);
        check("R4 low right after release write", 32'(dom_rst_n[4]), 32'h0);
        @(negedge clk);
        check("R4 low after one edge", 32'(dom_rst_n[4]), 32'h0);
        @(negedge clk);
        check("R4 high after two edges", 32'(dom_rst_n[4]), 32'h1);

        // R8: clear non-critical 1, then critical 2
        do_write(6'h04, 32'h0);
        do_write(6'h08, 32'h0);
        check("R8 critical domain low", 32'(dom_rst_n), 32'h39);
        quick_read("R8 critical reads 0 one cycle", 6'h08, 32'h0);
        @(negedge clk);
        quick_read("R8 critical self-restored", 6'h08, 32'h1);
        quick_read("R8 neighbour restored", 6'h04, 32'h1);
        check("R8 still low after 1 edge", 32'(dom_rst_n[2]), 32'h0);
        @(negedge clk);
        check("R8 still low after 2 edges", 32'(dom_rst_n[2]), 32'h0);
        @(negedge clk);
        check("R8 high after 3 edges", 32'(dom_rst_n), 32'h3F);

        // R5: watchdog asserts immediately and restores the bank
        do_write(6'h0C, 32'h0);
        #3 wdt_rst = 1'b1;
        #1;
        check("R5 immediate assert", 32'(dom_rst_n), 32'h0);
        @(negedge clk);
        wdt_rst = 1'b0;
        quick_read("R5 bank restored", 6'h0C, 32'h1);
        repeat (3) @(negedge clk);
        check("R5 release after watchdog", 32'(dom_rst_n), 32'h3F);

        // R1: power-on pulse mid-run
        do_write(6'h14, 32'h0);
        por_n = 1'b0;
        #1;
        check("R1 por immediate assert", 32'(dom_rst_n), 32'h0);
        @(negedge clk);
        por_n = 1'b1;
        quick_read("R1 por restores bit", 6'h14, 32'h1);
        repeat (3) @(negedge clk);
        check("R1 domains free again", 32'(dom_rst_n), 32'h3F);

        done = 1'b1;
        summary();
        $finish;
    end

    // Timeout: a hung run counts as one failed check
    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL timeout: actual running expected finished");
            summary();
            $finish;
        end
    end
endmodule